// File: doc/BRIEF.md
# Fast Ethernet Transmit Nibble-to-Code-Group Encoder

This block sits on the transmit side of a 100 Mb/s physical layer. Each cycle of the 25 MHz transmit clock it samples a 4-bit nibble together with an enable and an error strobe from the MAC. It then produces one 5-bit code group. A packet is framed on the line by the start pair J,K and the end pair T,R. All data positions in between carry the usual 4B/5B mapping. Between packets the line carries the idle code group.

When the MAC flags an error on a data position, the block sends an invalid code group in place of that nibble. The invalid code is normally HALT. A test-mode input swaps it for an alternate invalid code, which is set by a parameter. A second input marks 10 Mb/s operation, and in that mode the error strobe is ignored.

A configurable number of extra register stages follows the framing register. The sampling edge therefore reaches the output after `PIPE_EXTRA + 1` clocks. Scrambling, line coding and the receive path belong to other blocks.

Top module: `mii_tx_4b5b_enc`

## Requirements
- R1: A synchronous active-high `rst` forces every stage to the idle code group 11111 and forgets any frame in progress. The output shows 11111 from the first clock edge at which `rst` is sampled high.
- R2: While no frame is active or ending, each sampled cycle with `tx_en` low produces 11111.
- R3: At the first two edges that sample `tx_en` high after idle, the code groups are J = 11000 and then K = 10001. The nibbles sampled at those edges are not sent.
- R4: From the third enabled edge of a frame onward, each nibble n maps to code group C(n): 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: The first edge that samples `tx_en` low inside a frame produces T = 01101. The next edge produces R = 00111 whatever `tx_en` is, and the block then returns to idle. A frame that is enabled again starts over with J,K.
- R6: On a data position with `slow_10m` low and `err_test_mode` low, `tx_er` high replaces the nibble with HALT = 00100.
- R7: The same condition with `err_test_mode` high sends the parameter `ALT_INV_CODE` (default 00000) instead of HALT.
- R8: With `slow_10m` high, `tx_er` has no effect: data positions carry C(n).
- R9: A code group decided at a sampling edge appears on `sym_out` exactly `PIPE_EXTRA + 1` edges later. The default total is 2.
- R10: `tx_er` is ignored outside data positions: during idle, at the J and K positions, and on the T and R positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz transmit clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Nibble valid / frame active |
| tx_er | input | 1 | MAC error strobe |
| tx_nib | input | 4 | Transmit nibble |
| slow_10m | input | 1 | High selects 10 Mb/s operation |
| err_test_mode | input | 1 | High selects the alternate invalid code |
| sym_out | output | 5 | Encoded code group |

## Verification
The hardest cases to reach are the corners where frame boundaries meet other events. These include a frame that restarts while R is being sent, a frame of only one or two enabled cycles, and an error strobe that lands on the J or K position. Ordinary frames touch none of them. The stimulus therefore builds short, back-to-back enable patterns. It also sweeps every nibble with and without the error strobe across all four combinations of speed and test mode. A bench-side model predicts each code group from the requirements and compares it after the pipeline delay.

// File: rtl/mii4b5b_pkg.sv
package mii4b5b_pkg;

   localparam int NIB_W = 4;
   localparam int SYM_W = 5;

   typedef logic [SYM_W-1:0] sym_t;
   typedef logic [NIB_W-1:0] nib_t;

   localparam sym_t SYM_IDLE = 5'b11111;
   localparam sym_t SYM_J    = 5'b11000;
   localparam sym_t SYM_K    = 5'b10001;
   localparam sym_t SYM_T    = 5'b01101;
   localparam sym_t SYM_R    = 5'b00111;
   localparam sym_t SYM_HALT = 5'b00100;

   // Framing phase: what the previous sampling edge emitted.
   typedef enum logic [1:0] {
      FS_IDLE   = 2'd0,
      FS_SENT_J = 2'd1,
      FS_BODY   = 2'd2,
      FS_SENT_T = 2'd3
   } fstate_t;

   function automatic sym_t enc_nibble(input nib_t n);
      sym_t s;
      case (n)
         4'h0: s = 5'b11110;
         4'h1: s = 5'b01001;
         4'h2: s = 5'b10100;
         4'h3: s = 5'b10101;
         4'h4: s = 5'b01010;
         4'h5: s = 5'b01011;
         4'h6: s = 5'b01110;
         4'h7: s = 5'b01111;
         4'h8: s = 5'b10010;
         4'h9: s = 5'b10011;
         4'hA: s = 5'b10110;
         4'hB: s = 5'b10111;
         4'hC: s = 5'b11010;
         4'hD: s = 5'b11011;
         4'hE: s = 5'b11100;
         default: s = 5'b11101;
      endcase
      return s;
   endfunction

   // True when a code already carries meaning on the line.
   function automatic bit is_reserved(input sym_t s);
      bit hit;
      hit = (s == SYM_IDLE) || (s == SYM_J) || (s == SYM_K) ||
            (s == SYM_T) || (s == SYM_R) || (s == SYM_HALT);
      for (int i = 0; i < (1 << NIB_W); i++) begin
         if (enc_nibble(nib_t'(i)) == s) hit = 1'b1;
      end
      return hit;
   endfunction

endpackage

// File: rtl/m4b5b_map.sv
module m4b5b_map
   import mii4b5b_pkg::*;
#(
   parameter int IN_W  = 4,
   parameter int OUT_W = 5
) (
   input  logic [IN_W-1:0]  nib_i,
   output logic [OUT_W-1:0] sym_o
);

   generate
      if (IN_W != NIB_W || OUT_W != SYM_W) begin : g_bad_width
         $error("m4b5b_map: widths must be 4 in and 5 out");
      end
   endgenerate

   always_comb begin
      sym_o = enc_nibble(nib_i);
   end

endmodule

// File: rtl/m4b5b_err_sel.sv
module m4b5b_err_sel
   import mii4b5b_pkg::*;
#(
   parameter sym_t ALT_CODE = 5'b00000
) (
   input  logic tx_er_i,
   input  logic slow_i,
   input  logic alt_i,
   output logic hit_o,
   output sym_t code_o
);

   generate
      if (is_reserved(ALT_CODE)) begin : g_bad_alt
         $error("m4b5b_err_sel: alternate invalid code collides with a used code");
      end
   endgenerate

   always_comb begin
      hit_o  = tx_er_i & ~slow_i;
      code_o = alt_i ? ALT_CODE : SYM_HALT;
   end

endmodule

// File: rtl/m4b5b_frame.sv
module m4b5b_frame
   import mii4b5b_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic txen_i,
   input  logic err_hit_i,
   input  sym_t err_code_i,
   input  sym_t data_sym_i,
   output sym_t sym_q,
   output logic data_slot_o
);

   fstate_t st, st_nxt;
   sym_t    sym_nxt;
   logic    armed;

   always_comb begin
      st_nxt  = st;
      sym_nxt = SYM_IDLE;
      unique case (st)
         FS_IDLE: begin
            if (txen_i) begin
               sym_nxt = SYM_J;
               st_nxt  = FS_SENT_J;
            end
         end
         FS_SENT_J: begin
            if (txen_i) begin
               sym_nxt = SYM_K;
               st_nxt  = FS_BODY;
            end else begin
               sym_nxt = SYM_T;
               st_nxt  = FS_SENT_T;
            end
         end
         FS_BODY: begin
            if (txen_i) begin
               sym_nxt = err_hit_i ? err_code_i : data_sym_i;
            end else begin
               sym_nxt = SYM_T;
               st_nxt  = FS_SENT_T;
            end
         end
         FS_SENT_T: begin
            sym_nxt = SYM_R;
            st_nxt  = FS_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st    <= FS_IDLE;
         sym_q <= SYM_IDLE;
         armed <= 1'b0;
      end else begin
         st    <= st_nxt;
         sym_q <= sym_nxt;
         armed <= 1'b1;
      end
   end

   assign data_slot_o = (st == FS_BODY);

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
      armed && $past(st == FS_IDLE && !txen_i) |-> sym_q == SYM_IDLE);

   p_start_j_r3: assert property (@(posedge clk) disable iff (rst)
      armed && $past(st == FS_IDLE && txen_i) |-> sym_q == SYM_J);

   p_then_k_r3: assert property (@(posedge clk) disable iff (rst)
      armed && $past(st == FS_SENT_J && txen_i) |-> sym_q == SYM_K);

   p_end_t_r5: assert property (@(posedge clk) disable iff (rst)
      armed && $past((st == FS_SENT_J || st == FS_BODY) && !txen_i) |-> sym_q == SYM_T);

   p_t_then_r_r5: assert property (@(posedge clk) disable iff (rst)
      armed && $past(sym_q == SYM_T) |-> sym_q == SYM_R);

endmodule

// File: rtl/m4b5b_pipe.sv
module m4b5b_pipe
   import mii4b5b_pkg::*;
#(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst,
   input  sym_t d_i,
   output sym_t q_o
);

   generate
      if (STAGES < 0 || STAGES > 3) begin : g_bad_depth
         $error("m4b5b_pipe: STAGES must lie in 0..3");
      end
      if (STAGES == 0) begin : g_wire
         assign q_o = d_i;
      end else begin : g_regs
         sym_t sr [STAGES];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < STAGES; i++) sr[i] <= SYM_IDLE;
            end else begin
               sr[0] <= d_i;
               for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign q_o = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mii_tx_4b5b_enc.sv
module mii_tx_4b5b_enc
   import mii4b5b_pkg::*;
#(
   parameter int   PIPE_EXTRA   = 1,
   parameter sym_t ALT_INV_CODE = 5'b00000
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tx_en,
   input  logic       tx_er,
   input  logic [3:0] tx_nib,
   input  logic       slow_10m,
   input  logic       err_test_mode,
   output logic [4:0] sym_out
);

   localparam int LATENCY = PIPE_EXTRA + 1;

   sym_t data_sym, err_code, stage1_sym;
   logic err_hit, data_slot;
   logic seen_q, armed_q;

   m4b5b_map #(.IN_W(NIB_W), .OUT_W(SYM_W)) i_map (
      .nib_i (tx_nib),
      .sym_o (data_sym)
   );

   m4b5b_err_sel #(.ALT_CODE(ALT_INV_CODE)) i_err (
      .tx_er_i (tx_er),
      .slow_i  (slow_10m),
      .alt_i   (err_test_mode),
      .hit_o   (err_hit),
      .code_o  (err_code)
   );

   m4b5b_frame i_frame (
      .clk         (clk),
      .rst         (rst),
      .txen_i      (tx_en),
      .err_hit_i   (err_hit),
      .err_code_i  (err_code),
      .data_sym_i  (data_sym),
      .sym_q       (stage1_sym),
      .data_slot_o (data_slot)
   );

   m4b5b_pipe #(.STAGES(PIPE_EXTRA)) i_pipe (
      .clk (clk),
      .rst (rst),
      .d_i (stage1_sym),
      .q_o (sym_out)
   );

   generate
      if (LATENCY < 1) begin : g_bad_lat
         $error("mii_tx_4b5b_enc: latency must be at least one clock");
      end
   endgenerate

   always_ff @(posedge clk) begin
      seen_q  <= 1'b1;
      armed_q <= ~rst;
   end

   p_reset_idle_r1: assert property (@(posedge clk)
      seen_q && $past(rst) |-> sym_out == SYM_IDLE);

   p_halt_sub_r6: assert property (@(posedge clk) disable iff (rst)
      armed_q && $past(data_slot && tx_en && tx_er && !slow_10m && !err_test_mode)
      |-> stage1_sym == SYM_HALT);

   p_alt_sub_r7: assert property (@(posedge clk) disable iff (rst)
      armed_q && $past(data_slot && tx_en && tx_er && !slow_10m && err_test_mode)
      |-> stage1_sym == ALT_INV_CODE);

   p_slow_ignores_er_r8: assert property (@(posedge clk) disable iff (rst)
      armed_q && $past(data_slot && tx_en && slow_10m)
      |-> stage1_sym == enc_nibble($past(tx_nib)));

   p_data_map_r4: assert property (@(posedge clk) disable iff (rst)
      armed_q && $past(data_slot && tx_en && !tx_er)
      |-> stage1_sym == enc_nibble($past(tx_nib)));

endmodule

// File: tb/test_mii_tx_4b5b_enc.sv
`timescale 1ns/1ps
module test_mii_tx_4b5b_enc;

   localparam int         EXTRA = 1;
   localparam int         LAT   = EXTRA + 1;
   localparam logic [4:0] ALT   = 5'b00000;
   localparam logic [4:0] C_IDLE = 5'b11111, C_J = 5'b11000, C_K = 5'b10001,
                          C_T = 5'b01101, C_R = 5'b00111, C_HALT = 5'b00100;
   localparam logic [4:0] TAB [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                       5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                       5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                       5'b11010, 5'b11011, 5'b11100, 5'b11101};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tx_en = 1'b0, tx_er = 1'b0, slow_10m = 1'b0, err_test_mode = 1'b0;
   logic [3:0] tx_nib = 4'h0;
   logic [4:0] sym_out;

   int checks = 0;
   int fails  = 0;
   int k      = 0;
   int pos    = 0;
   bit tail   = 1'b0;
   bit done   = 1'b0;

   logic [4:0] exp_s [256];
   bit         exp_v [256];
   string      exp_t [256];

   always #2.5 clk = ~clk;

   mii_tx_4b5b_enc #(.PIPE_EXTRA(EXTRA), .ALT_INV_CODE(ALT)) i_mii_tx_4b5b_enc (
      .clk           (clk),
      .rst           (rst),
      .tx_en         (tx_en),
      .tx_er         (tx_er),
      .tx_nib        (tx_nib),
      .slow_10m      (slow_10m),
      .err_test_mode (err_test_mode),
      .sym_out       (sym_out)
   );

   task automatic check_now(input logic [4:0] exp, input string tag);
      checks++;
      if (sym_out !== exp) begin
         fails++;
         $display("FAIL %s cycle=%0d actual=%b expected=%b", tag, k, sym_out, exp);
      end
   endtask

   task automatic step(input bit en, input bit er, input logic [3:0] d,
                       input bit slow, input bit tm);
      logic [4:0] e;
      string      tag;
      int         idx;
      @(negedge clk);
      idx = k % 256;
      if (exp_v[idx]) begin
         check_now(exp_s[idx], exp_t[idx]);
         exp_v[idx] = 1'b0;
      end
      tx_en = en; tx_er = er; tx_nib = d; slow_10m = slow; err_test_mode = tm;
      if (tail) begin
         e = C_R; tag = "R5"; tail = 1'b0; pos = 0;
      end else if (en) begin
         if (pos == 0) begin
            e = C_J; tag = er ? "R3 R9 R10" : "R3 R9";
         end else if (pos == 1) begin
            e = C_K; tag = er ? "R3 R10" : "R3";
         end else if (er && !slow) begin
            e = tm ? ALT : C_HALT; tag = tm ? "R7" : "R6";
         end else begin
            e = TAB[d]; tag = (er && slow) ? "R8" : "R4";
         end
         pos++;
      end else if (pos > 0) begin
         e = C_T; tag = "R5"; tail = 1'b1; pos = 0;
      end else begin
         e = C_IDLE; tag = er ? "R2 R10" : "R2";
      end
      idx = (k + LAT) % 256;
      exp_s[idx] = e; exp_v[idx] = 1'b1; exp_t[idx] = tag;
      k++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; tx_en = 1'b0; tx_er = 1'b0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 256; i++) exp_v[i] = 1'b0;
      pos = 0; tail = 1'b0;
      check_now(C_IDLE, "R1");
      rst = 1'b0;
   endtask

   task automatic idle(input int n, input bit er);
      for (int i = 0; i < n; i++) step(1'b0, er ^ i[0], 4'h0, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R9 watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      for (int i = 0; i < 256; i++) exp_v[i] = 1'b0;
      do_reset();
      idle(6, 1'b1);                       // R2, R10 error strobe outside frame
      // R3 R4 R5: plain frame carrying every nibble in order
      for (int i = 0; i < 18; i++) step(1'b1, 1'b0, 4'(i), 1'b0, 1'b0);
      idle(4, 1'b0);
      // R6 R7 R8 R10: every nibble with and without the error strobe,
      // across both speeds and both test-mode settings
      for (int s = 0; s < 2; s++) begin
         for (int t = 0; t < 2; t++) begin
            step(1'b1, 1'b1, 4'h3, s[0], t[0]);
            step(1'b1, 1'b1, 4'h5, s[0], t[0]);
            for (int i = 0; i < 32; i++) step(1'b1, i[4], 4'(i), s[0], t[0]);
            step(1'b0, 1'b1, 4'h0, s[0], t[0]);
            step(1'b0, 1'b1, 4'h0, s[0], t[0]);
            idle(2, 1'b0);
         end
      end
      // R5: one-cycle frame, two-cycle frame, restart during R
      step(1'b1, 1'b0, 4'h1, 1'b0, 1'b0);
      idle(3, 1'b0);
      step(1'b1, 1'b0, 4'h1, 1'b0, 1'b0);
      step(1'b1, 1'b0, 4'h2, 1'b0, 1'b0);
      idle(3, 1'b0);
      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 4'(i + 7), 1'b0, 1'b0);
         step(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
      end
      step(1'b1, 1'b0, 4'h9, 1'b0, 1'b0);  // en high in R slot is ignored
      step(1'b1, 1'b0, 4'hA, 1'b0, 1'b0);
      step(1'b1, 1'b0, 4'hB, 1'b0, 1'b0);
      idle(4, 1'b0);
      // R1: reset in the middle of a frame
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 4'(i), 1'b0, 1'b0);
      do_reset();
      idle(LAT + 1, 1'b0);
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 4'(i + 12), 1'b0, 1'b0);
      idle(LAT + 3, 1'b0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule